// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block takes sixteen request lines and picks one winner by a fixed ranking. It then gives the CPU the two-byte vector address of that winner. Slot 0 is the reset source and ranks highest. Slot 1 is the software trap. Slots 2 to 15 are maskable sources, ranked in index order. The vector of slot `i` is `FFFEh - 2*i`, so the sixteen vectors run from `FFFEh` down to `FFE0h`. The result is registered and raised as a request strobe. The vector then stays frozen until the CPU acknowledges it.

In parallel, a wake-up path watches the low-power mode input.

- **Halt:** a request may end the low-power state only if that source has its wake capability bit set.
- **Serial port slot:** its request also needs the peripheral to be in slave mode.
- **PWM timer slot:** its request also needs the timer to run from its external clock.
- **Active halt:** only the reset slot or the time-base slot may wake the device.

The wake output is a single-cycle pulse.

Top module: `vec_int_ctrl`

## Requirements
- R1: The vector for slot `i` is `FFFEh - 2*i`. Slot 0 gives `FFFEh`, slot 2 gives `FFFAh`, slot 9 gives `FFECh`, slot 14 gives `FFE2h` and slot 15 gives `FFE0h`.
- R2: When several accepted requests are present together, the lowest slot index wins.
- R3: When `mask_lvl` equals 3, requests on slots 2 to 15 are not accepted. Slots 0 and 1 are accepted at every mask level.
- R4: While the strobe is low, an accepted request raises `irq_strobe` after one clock edge, with its vector on `vec_addr`. While the strobe is high and no acknowledge is given, `vec_addr` does not change, even if a higher-ranked request arrives.
- R5: `irq_ack` while the strobe is high clears the strobe at the next edge. Pending requests are evaluated again from the edge after that.
- R6: `wake` never rises while `lp_mode` is 0 (run) or 3 (reserved).
- R7: In halt (`lp_mode` = 1), only slots whose wake capability bit is set can raise `wake`. The default capability set is slots 0, 2, 3, 5, 6, 7, 8, 9 and 15. Slots 1, 4 and 10 to 14 never wake.
- R8: In halt, slot 9 wakes only while `spi_slave` is 1, and slot 15 wakes only while `pwm_extclk` is 1.
- R9: In active halt (`lp_mode` = 2), only slot 0 and slot 3 can raise `wake`.
- R10: `wake` is a one-cycle pulse. It is raised one edge after the wake condition first becomes true, and a condition that stays true gives no second pulse.
- R11: After reset, `irq_strobe` is 0, `vec_addr` is `FFFEh` and `wake` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Request lines; bit `i` is slot `i` |
| mask_lvl | input | 2 | CPU mask level; 3 blocks slots 2 to 15 |
| lp_mode | input | 2 | 0 run, 1 halt, 2 active halt, 3 reserved |
| spi_slave | input | 1 | Serial port is in slave mode |
| pwm_extclk | input | 1 | PWM timer is running from its external clock |
| irq_ack | input | 1 | CPU has taken the presented vector |
| irq_strobe | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Vector address of the latched winner |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The strobe and vector change one rising edge after a request is driven. The wake pulse follows one edge after its qualifying condition. The strobe falls one edge after an acknowledge and rises again at the edge after that if a request remains. The bench drives every input on a falling edge and reads outputs on the following falling edge, so each check lands exactly one register stage after its stimulus. For the hold and single-pulse rules, it also looks one more cycle ahead.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // Number of request slots and derived index width
    localparam int unsigned SRC_N = 16;
    localparam int unsigned IDX_W = $clog2(SRC_N);
    localparam int unsigned VEC_W = 16;

    // Low-power mode encoding seen on lp_mode
    typedef enum logic [1:0] {
        LP_RUN   = 2'b00,
        LP_HALT  = 2'b01,
        LP_AHALT = 2'b10,
        LP_RSVD  = 2'b11
    } lp_mode_e;

    // Registered state of the controller
    typedef struct packed {
        logic             strobe;
        logic [VEC_W-1:0] vec;
        logic             wake;
        logic             cand;
    } vic_state_t;

endpackage

// File: rtl/vic_mask_gate.sv
module vic_mask_gate #(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned FREE_CNT = 2
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [1:0]         mask_lvl,
    output logic [NUM_SRC-1:0] elig
);

    // Level 3 blocks every source from FREE_CNT upward
    logic block;
    assign block = (mask_lvl == 2'b11);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        if (g < FREE_CNT) begin : g_free
            assign elig[g] = req[g];
        end else begin : g_maskable
            assign elig[g] = req[g] & ~block;
        end
    end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the lowest rank upward; the last hit is the lowest index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_wake_gate.sv
module vic_wake_gate
    import vic_pkg::*;
#(
    parameter int unsigned          NUM_SRC  = 16,
    parameter logic [NUM_SRC-1:0]   WAKE_CAP = 16'h83ED,
    parameter int unsigned          SPI_SLOT = 9,
    parameter int unsigned          PWM_SLOT = 15,
    parameter int unsigned          TB_SLOT  = 3
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [1:0]         lp_mode,
    input  logic               spi_slave,
    input  logic               pwm_extclk,
    output logic               any_wake
);

    logic [NUM_SRC-1:0] halt_ok;
    logic [NUM_SRC-1:0] ahalt_ok;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        // Halt: per-source capability plus peripheral mode qualifiers
        if (WAKE_CAP[g] == 1'b0) begin : g_nocap
            assign halt_ok[g] = 1'b0;
        end else if (g == SPI_SLOT) begin : g_spi
            assign halt_ok[g] = req[g] & spi_slave;
        end else if (g == PWM_SLOT) begin : g_pwm
            assign halt_ok[g] = req[g] & pwm_extclk;
        end else begin : g_cap
            assign halt_ok[g] = req[g];
        end

        // Active halt: only reset slot and time-base slot
        if (g == 0 || g == TB_SLOT) begin : g_ah
            assign ahalt_ok[g] = req[g];
        end else begin : g_noah
            assign ahalt_ok[g] = 1'b0;
        end
    end

    always_comb begin
        unique case (lp_mode)
            LP_HALT:  any_wake = |halt_ok;
            LP_AHALT: any_wake = |ahalt_ok;
            default:  any_wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/vec_int_ctrl.sv
module vec_int_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned          NUM_SRC  = SRC_N,
    parameter int unsigned          FREE_CNT = 2,
    parameter logic [VEC_W-1:0]     VEC_TOP  = 16'hFFFE,
    parameter logic [NUM_SRC-1:0]   WAKE_CAP = 16'h83ED,
    parameter int unsigned          SPI_SLOT = 9,
    parameter int unsigned          PWM_SLOT = 15,
    parameter int unsigned          TB_SLOT  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [1:0]         mask_lvl,
    input  logic [1:0]         lp_mode,
    input  logic               spi_slave,
    input  logic               pwm_extclk,
    input  logic               irq_ack,
    output logic               irq_strobe,
    output logic [VEC_W-1:0]   vec_addr,
    output logic               wake
);

    localparam int unsigned IDX_LW = $clog2(NUM_SRC);

    vic_state_t st_d, st_q;

    logic [NUM_SRC-1:0] elig;
    logic               win_found;
    logic [IDX_LW-1:0]  win_idx;
    logic               wake_any;

    vic_mask_gate #(
        .NUM_SRC  (NUM_SRC),
        .FREE_CNT (FREE_CNT)
    ) u_mask (
        .req      (irq_req),
        .mask_lvl (mask_lvl),
        .elig     (elig)
    );

    vic_prio_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .req   (elig),
        .found (win_found),
        .idx   (win_idx)
    );

    vic_wake_gate #(
        .NUM_SRC  (NUM_SRC),
        .WAKE_CAP (WAKE_CAP),
        .SPI_SLOT (SPI_SLOT),
        .PWM_SLOT (PWM_SLOT),
        .TB_SLOT  (TB_SLOT)
    ) u_wake (
        .req        (irq_req),
        .lp_mode    (lp_mode),
        .spi_slave  (spi_slave),
        .pwm_extclk (pwm_extclk),
        .any_wake   (wake_any)
    );

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        // Wake pulse on the first cycle the condition holds
        st_d.cand = wake_any;
        st_d.wake = wake_any & ~st_q.cand;
        if (st_q.strobe) begin
            // Vector frozen until the CPU takes it
            if (irq_ack) begin
                st_d.strobe = 1'b0;
            end
        end else if (win_found) begin
            st_d.strobe = 1'b1;
            st_d.vec    = VEC_TOP - VEC_W'({win_idx, 1'b0});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{strobe: 1'b0, vec: VEC_TOP, wake: 1'b0, cand: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_strobe = st_q.strobe;
    assign vec_addr   = st_q.vec;
    assign wake       = st_q.wake;

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rq_top,
    input logic        rq_trap,
    input logic        rq_tb,
    input logic [1:0]  mask_lvl,
    input logic [1:0]  lp_mode,
    input logic        irq_ack,
    input logic        irq_strobe,
    input logic [15:0] vec_addr,
    input logic        wake
);

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> (vec_addr[0] == 1'b0 && vec_addr >= 16'hFFE0)); // R1

    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_strobe && rq_top) |=> (irq_strobe && vec_addr == VEC_TOP)); // R2

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_strobe && mask_lvl == 2'b11 && !rq_top && !rq_trap) |=> !irq_strobe); // R3

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_strobe && !irq_ack) |=> (irq_strobe && $stable(vec_addr))); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_strobe && irq_ack) |=> !irq_strobe); // R5

    AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == 2'b00 || lp_mode == 2'b11) |=> !wake); // R6

    AST_AHALT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == 2'b10 && !rq_top && !rq_tb) |=> !wake); // R9

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake); // R10

endmodule

bind vec_int_ctrl vic_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rq_top     (irq_req[0]),
    .rq_trap    (irq_req[1]),
    .rq_tb      (irq_req[TB_SLOT]),
    .mask_lvl   (mask_lvl),
    .lp_mode    (lp_mode),
    .irq_ack    (irq_ack),
    .irq_strobe (irq_strobe),
    .vec_addr   (vec_addr),
    .wake       (wake)
);

// File: tb/vec_int_ctrl_test.sv
`timescale 1ns/1ps
module vec_int_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [1:0]  mask_lvl = '0;
    logic [1:0]  lp_mode = '0;
    logic        spi_slave = 1'b0;
    logic        pwm_extclk = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_strobe;
    logic [15:0] vec_addr;
    logic        wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vec_int_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .mask_lvl   (mask_lvl),
        .lp_mode    (lp_mode),
        .spi_slave  (spi_slave),
        .pwm_extclk (pwm_extclk),
        .irq_ack    (irq_ack),
        .irq_strobe (irq_strobe),
        .vec_addr   (vec_addr),
        .wake       (wake)
    );

    // Entry: {tag[3:0], req[15:0], mask[1:0], vec[15:0], strobe}
    localparam int NV = 8;
    localparam logic [38:0] VECS [NV] = '{
        {4'd1, 16'h0004, 2'd0, 16'hFFFA, 1'b1},  // R1 slot 2
        {4'd1, 16'h8000, 2'd0, 16'hFFE0, 1'b1},  // R1 slot 15
        {4'd2, 16'h8420, 2'd0, 16'hFFF4, 1'b1},  // R2 slot 5 beats 10, 15
        {4'd3, 16'h0006, 2'd3, 16'hFFFC, 1'b1},  // R3 trap passes mask
        {4'd3, 16'h0FF0, 2'd3, 16'h0000, 1'b0},  // R3 all blocked
        {4'd2, 16'h0003, 2'd3, 16'hFFFE, 1'b1},  // R2 reset beats trap
        {4'd1, 16'h4000, 2'd2, 16'hFFE2, 1'b1},  // R1 slot 14, level 2
        {4'd1, 16'h0200, 2'd0, 16'hFFEC, 1'b1}   // R1 slot 9
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear();
        irq_req = '0;
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        step();
    endtask

    task automatic wake_case(string tag, int src, logic [1:0] lp, logic spi, logic pwm, logic exp);
        lp_mode    = lp;
        spi_slave  = spi;
        pwm_extclk = pwm;
        irq_req    = '0;
        step();
        irq_req = 16'(1) << src;
        step();
        check(tag, "wake", {15'd0, wake}, {15'd0, exp});
        step();
        check("R10", "wake second cycle", {15'd0, wake}, 16'd0);
        clear();
        lp_mode    = 2'b00;
        spi_slave  = 1'b0;
        pwm_extclk = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R11", "strobe after reset", {15'd0, irq_strobe}, 16'd0);
        check("R11", "vector after reset", vec_addr, 16'hFFFE);
        check("R11", "wake after reset", {15'd0, wake}, 16'd0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            string tg;
            tg = $sformatf("R%0d", VECS[k][38:35]);
            irq_req  = VECS[k][34:19];
            mask_lvl = VECS[k][18:17];
            step();
            check(tg, "strobe", {15'd0, irq_strobe}, {15'd0, VECS[k][0]});
            if (VECS[k][0]) check(tg, "vector", vec_addr, VECS[k][16:1]);
            mask_lvl = 2'd0;
            clear();
        end

        // R4: vector held while a higher slot arrives
        irq_req = 16'h0400;
        step();
        check("R4", "vector slot 10", vec_addr, 16'hFFEA);
        irq_req = 16'h0401;
        step();
        check("R4", "strobe held", {15'd0, irq_strobe}, 16'd1);
        check("R4", "vector held", vec_addr, 16'hFFEA);
        step();
        check("R4", "vector still held", vec_addr, 16'hFFEA);
        // R5: acknowledge clears, then re-evaluation picks slot 0
        irq_ack = 1'b1;
        step();
        check("R5", "strobe after ack", {15'd0, irq_strobe}, 16'd0);
        irq_ack = 1'b0;
        step();
        check("R5", "strobe re-raised", {15'd0, irq_strobe}, 16'd1);
        check("R5", "vector re-evaluated", vec_addr, 16'hFFFE);
        clear();

        // Wake cases
        wake_case("R7", 5, 2'b01, 1'b0, 1'b0, 1'b1);
        wake_case("R7", 10, 2'b01, 1'b1, 1'b1, 1'b0);
        wake_case("R7", 1, 2'b01, 1'b0, 1'b0, 1'b0);
        wake_case("R8", 9, 2'b01, 1'b0, 1'b1, 1'b0);
        wake_case("R8", 9, 2'b01, 1'b1, 1'b0, 1'b1);
        wake_case("R8", 15, 2'b01, 1'b1, 1'b0, 1'b0);
        wake_case("R8", 15, 2'b01, 1'b0, 1'b1, 1'b1);
        wake_case("R9", 5, 2'b10, 1'b0, 1'b0, 1'b0);
        wake_case("R9", 3, 2'b10, 1'b0, 1'b0, 1'b1);
        wake_case("R9", 0, 2'b10, 1'b0, 1'b0, 1'b1);
        wake_case("R6", 5, 2'b00, 1'b0, 1'b0, 1'b0);
        wake_case("R6", 0, 2'b11, 1'b0, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule